// File: doc/BRIEF.md
# Coprocessor Integer Compare Flag Unit

This block compares two integer operands held in a file of sixteen 64-bit coprocessor registers and returns a 32-bit status word whose top nibble carries the negative, zero, carry and overflow flags of the subtraction first-minus-second. The requester presents a 32-bit instruction word together with a one-cycle request strobe. The block extracts the two register indexes and the opcode from fixed fields of that word. It drives the indexes onto a read port of the register file, which lies outside the block and answers combinationally. It then registers the packed flag word.

Two compare widths exist. The narrow compare uses only the low 32-bit half of each register. The wide compare uses the full 64 bits, with the upper half as the most significant word. Any other opcode raises a one-cycle illegal-opcode pulse instead of a result.

A small state machine sequences the response. The states are ST_IDLE (no response this cycle), ST_RESULT (flag word valid this cycle) and ST_FAULT (illegal opcode reported this cycle). From every state the transitions are the same. A request with opcode 4 or 5 moves the machine to ST_RESULT. A request with any other opcode moves it to ST_FAULT. A cycle without a request returns it to ST_IDLE.

Top module: `cmpu_top`

## Requirements
- R1: After reset, `res_valid` and `op_illegal` are low and `flag_word` is zero.
- R2: Opcode 4 (instruction bits 7:5) compares only bits 31:0 of both registers; the upper halves have no effect on the flags.
- R3: Opcode 5 compares full 64-bit operands, with register bits 63:32 as the most significant word.
- R4: N (bit 31) is the sign bit of the difference first-minus-second. Z (bit 30) is set exactly when that difference is zero.
- R5: V (bit 28) is set when the operand signs differ and the sign of the difference differs from the sign of the first operand.
- R6: C (bit 29) is set when the first operand is at or above the second operand taken as unsigned values, meaning no borrow occurs.
- R7: Bits 27:0 of `flag_word` are always zero.
- R8: A request with any opcode other than 4 or 5 produces a one-cycle `op_illegal` pulse with `res_valid` low and `flag_word` zero.
- R9: The first register index is instruction bits 19:16 and the second is bits 3:0. `rd_idx_a` and `rd_idx_b` follow these fields in the same cycle, and other instruction bits do not affect them.
- R10: Each request yields exactly one response, registered one clock after the strobe. Back-to-back requests give back-to-back responses, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Compare request strobe |
| instr | input | 32 | Instruction word carrying opcode and register indexes |
| rd_idx_a | output | 4 | Register file read index, first operand |
| rd_idx_b | output | 4 | Register file read index, second operand |
| rd_data_a | input | 64 | Register file read data, first operand |
| rd_data_b | input | 64 | Register file read data, second operand |
| flag_word | output | 32 | Packed N,Z,C,V flags in bits 31:28 |
| res_valid | output | 1 | One-cycle pulse: flag_word holds a new result |
| op_illegal | output | 1 | One-cycle pulse: the request carried an unknown opcode |

## Verification
Every cycle, the assertions check several structural properties of the response. The valid and illegal pulses never coincide. Each pulse is preceded by a request. An error response carries a zero word, and the low 28 bits always stay clear. A valid word never shows N and Z together, and Z always implies C. The actual flag values depend on the operand data. They are therefore shown only by the bench's scenarios, which cover equal, signed-overflow, unsigned-borrow and upper-half-only differences at both widths, illegal opcodes and back-to-back requests.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
    localparam int INSTR_W   = 32;
    localparam int IDX_W     = 4;
    localparam int OPC_W     = 3;
    localparam int OPC_LSB   = 5;
    localparam int IDXA_LSB  = 16;
    localparam int IDXB_LSB  = 0;
    localparam logic [OPC_W-1:0] OPC_NARROW = 3'd4;
    localparam logic [OPC_W-1:0] OPC_WIDE   = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } cmpu_state_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cmpu_flags_t;
endpackage

// File: rtl/cmpu_decode.sv
module cmpu_decode
    import cmpu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [IDX_W-1:0]   idx_a,
    output logic [IDX_W-1:0]   idx_b,
    output logic               sel_narrow,
    output logic               sel_wide
);
    logic [OPC_W-1:0] opcode;

    always_comb begin
        idx_a      = instr[IDXA_LSB +: IDX_W];
        idx_b      = instr[IDXB_LSB +: IDX_W];
        opcode     = instr[OPC_LSB +: OPC_W];
        sel_narrow = (opcode == OPC_NARROW);
        sel_wide   = (opcode == OPC_WIDE);
    end
endmodule

// File: rtl/cmpu_flag_calc.sv
module cmpu_flag_calc
    import cmpu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output cmpu_flags_t  flags
);
    localparam int MSB = W - 1;

    logic [W-1:0] diff;
    logic         sa;
    logic         sb;
    logic         sd;

    always_comb begin
        diff    = opa - opb;
        sa      = opa[MSB];
        sb      = opb[MSB];
        sd      = diff[MSB];
        flags.n = sd;
        flags.z = (diff == '0);
        flags.v = (sa != sb) && (sd != sa);
        // no borrow: first negative with second non-negative, or either
        // sign pair that leaves the difference non-negative
        flags.c = (sa && !sb) || (sa && !sd) || (!sb && !sd);
    end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
    import cmpu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [INSTR_W-1:0]  instr,
    output logic [IDX_W-1:0]    rd_idx_a,
    output logic [IDX_W-1:0]    rd_idx_b,
    input  logic [DATA_W-1:0]   rd_data_a,
    input  logic [DATA_W-1:0]   rd_data_b,
    output logic [WORD_W-1:0]   flag_word,
    output logic                res_valid,
    output logic                op_illegal
);
    localparam int HALF_W = DATA_W / 2;
    localparam int PAD_W  = WORD_W - 4;

    logic        sel_narrow;
    logic        sel_wide;
    cmpu_flags_t flags_narrow;
    cmpu_flags_t flags_wide;
    cmpu_flags_t flags_sel;
    logic        legal;

    cmpu_state_t        state_q;
    cmpu_state_t        state_d;
    logic [WORD_W-1:0]  word_q;

    cmpu_decode u_decode (
        .instr      (instr),
        .idx_a      (rd_idx_a),
        .idx_b      (rd_idx_b),
        .sel_narrow (sel_narrow),
        .sel_wide   (sel_wide)
    );

    cmpu_flag_calc #(.W(HALF_W)) u_calc_narrow (
        .opa   (rd_data_a[HALF_W-1:0]),
        .opb   (rd_data_b[HALF_W-1:0]),
        .flags (flags_narrow)
    );

    cmpu_flag_calc #(.W(DATA_W)) u_calc_wide (
        .opa   (rd_data_a),
        .opb   (rd_data_b),
        .flags (flags_wide)
    );

    always_comb begin
        legal     = sel_narrow || sel_wide;
        flags_sel = sel_wide ? flags_wide : flags_narrow;
    end

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (req && legal)
                    state_d = ST_RESULT;
                else if (req)
                    state_d = ST_FAULT;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // result register, written on every request
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (req && legal)
            word_q <= {flags_sel, {PAD_W{1'b0}}};
        else if (req)
            word_q <= '0;
    end

    // outputs
    always_comb begin
        flag_word  = word_q;
        res_valid  = 1'b0;
        op_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: res_valid  = 1'b1;
            ST_FAULT:  op_illegal = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker
    import cmpu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [WORD_W-1:0] flag_word,
    input logic              res_valid,
    input logic              op_illegal
);
    // R8
    a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && op_illegal));

    // R8
    a_r8_fault_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> (flag_word == '0));

    // R10
    a_r10_resp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (res_valid || op_illegal));

    // R10
    a_r10_no_resp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!res_valid && !op_illegal));

    // R7
    a_r7_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_word[WORD_W-5:0] == '0);

    // R4
    a_r4_n_z_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(flag_word[WORD_W-1] && flag_word[WORD_W-2]));

    // R6
    a_r6_equal_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flag_word[WORD_W-2]) |-> flag_word[WORD_W-3]);
endmodule

bind cmpu_top cmpu_checker #(.WORD_W(WORD_W)) u_cmpu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .flag_word  (flag_word),
    .res_valid  (res_valid),
    .op_illegal (op_illegal)
);

// File: tb/cmpu_top_bench.sv
module cmpu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] instr = '0;
    logic [3:0]  rd_idx_a;
    logic [3:0]  rd_idx_b;
    logic [63:0] rd_data_a;
    logic [63:0] rd_data_b;
    logic [31:0] flag_word;
    logic        res_valid;
    logic        op_illegal;

    logic [63:0] rf [16];

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    always_comb begin
        rd_data_a = rf[rd_idx_a];
        rd_data_b = rf[rd_idx_b];
    end

    cmpu_top u_cmpu_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .instr      (instr),
        .rd_idx_a   (rd_idx_a),
        .rd_idx_b   (rd_idx_b),
        .rd_data_a  (rd_data_a),
        .rd_data_b  (rd_data_b),
        .flag_word  (flag_word),
        .res_valid  (res_valid),
        .op_illegal (op_illegal)
    );

    function automatic logic [31:0] model_narrow(input logic [31:0] a, input logic [31:0] b);
        logic signed [32:0] sd;
        logic [31:0] d;
        logic n, z, c, v;
        sd = $signed({a[31], a}) - $signed({b[31], b});
        d  = a - b;
        n  = d[31];
        z  = (a == b);
        c  = (a >= b);
        v  = (sd[32] != sd[31]);
        return {n, z, c, v, 28'h0};
    endfunction

    function automatic logic [31:0] model_wide(input logic [63:0] a, input logic [63:0] b);
        logic signed [64:0] sd;
        logic [63:0] d;
        logic n, z, c, v;
        sd = $signed({a[63], a}) - $signed({b[63], b});
        d  = a - b;
        n  = d[63];
        z  = (a == b);
        c  = (a >= b);
        v  = (sd[64] != sd[63]);
        return {n, z, c, v, 28'h0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: issue one request and push its expected response
    task automatic issue(input logic [2:0] op, input logic [3:0] ia, input logic [3:0] ib,
                         input logic [31:0] noise, input string tag);
        exp_t e;
        logic [31:0] w;
        @(negedge clk);
        w = noise;
        w[7:5]   = op;
        w[19:16] = ia;
        w[3:0]   = ib;
        instr = w;
        req   = 1'b1;
        if (op == 3'd4) begin
            e.word = model_narrow(rf[ia][31:0], rf[ib][31:0]);
            e.err  = 1'b0;
        end else if (op == 3'd5) begin
            e.word = model_wide(rf[ia], rf[ib]);
            e.err  = 1'b0;
        end else begin
            e.word = 32'h0;
            e.err  = 1'b1;
        end
        e.tag = tag;
        sb_q.push_back(e);
        #1;
        check("R9 idx_a", {28'h0, rd_idx_a}, {28'h0, ia});
        check("R9 idx_b", {28'h0, rd_idx_b}, {28'h0, ib});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 1'b0;
        end
    endtask

    // monitor: pop and compare on each response
    initial begin
        forever begin
            logic had;
            @(posedge clk);
            had = req && rst_n;
            #1;
            if (rst_n) begin
                if (had) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " word"}, flag_word, e.word);
                    check({e.tag, " valid"}, {31'h0, res_valid}, {31'h0, !e.err});
                    check({e.tag, " illegal"}, {31'h0, op_illegal}, {31'h0, e.err});
                end else if (res_valid || op_illegal) begin
                    check("R10 spurious response", {30'h0, res_valid, op_illegal}, 32'h0);
                end
            end
        end
    end

    initial begin
        #150000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 64'h0;
        rf[1]  = 64'h0000_0000_0000_0005;
        rf[2]  = 64'h0000_0000_0000_0003;
        rf[3]  = 64'hAAAA_0000_0000_0005;   // same low half as rf[1]
        rf[4]  = 64'h0000_0000_7FFF_FFFF;
        rf[5]  = 64'h0000_0000_FFFF_FFFF;   // low -1
        rf[6]  = 64'h0000_0000_8000_0000;   // low min
        rf[7]  = 64'h7FFF_FFFF_FFFF_FFFF;
        rf[8]  = 64'hFFFF_FFFF_FFFF_FFFF;
        rf[9]  = 64'h8000_0000_0000_0000;
        rf[10] = 64'h0000_0001_0000_0000;   // differs from rf[0] only in upper half
        rf[15] = 64'h1234_5678_9ABC_DEF0;

        repeat (3) @(negedge clk);
        #1;
        check("R1 word", flag_word, 32'h0);
        check("R1 pulses", {30'h0, res_valid, op_illegal}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        issue(3'd4, 4'd1, 4'd2, 32'h0, "R2 R6 narrow greater");
        idle(1);
        issue(3'd4, 4'd2, 4'd1, 32'h0, "R4 narrow less");
        idle(1);
        issue(3'd4, 4'd1, 4'd3, 32'h0, "R2 upper halves ignored");
        issue(3'd4, 4'd4, 4'd5, 32'h0, "R5 narrow overflow pos-neg");
        issue(3'd4, 4'd6, 4'd1, 32'h0, "R5 narrow overflow neg-pos");
        issue(3'd4, 4'd5, 4'd2, 32'h0, "R6 narrow unsigned no borrow");
        issue(3'd4, 4'd15, 4'd15, 32'h0, "R4 narrow equal");
        issue(3'd4, 4'd0, 4'd10, 32'h0, "R2 narrow upper-only diff");
        issue(3'd5, 4'd0, 4'd10, 32'h0, "R3 wide upper word");
        issue(3'd5, 4'd1, 4'd3, 32'h0, "R3 wide upper differs");
        issue(3'd5, 4'd7, 4'd8, 32'h0, "R5 wide overflow");
        issue(3'd5, 4'd9, 4'd1, 32'h0, "R5 wide min minus pos");
        issue(3'd5, 4'd8, 4'd8, 32'h0, "R4 wide equal");
        issue(3'd5, 4'd2, 4'd15, 32'h0, "R6 wide borrow");
        idle(2);
        issue(3'd0, 4'd1, 4'd2, 32'h0, "R8 opcode 0");
        issue(3'd3, 4'd1, 4'd2, 32'h0, "R8 opcode 3");
        issue(3'd6, 4'd1, 4'd2, 32'h0, "R8 opcode 6");
        issue(3'd7, 4'd1, 4'd2, 32'h0, "R8 opcode 7");
        issue(3'd4, 4'd4, 4'd5, 32'hFFF0_FF10, "R9 noisy fields");
        issue(3'd5, 4'd7, 4'd9, 32'h0F00_E000, "R9 noisy wide");
        issue(3'd4, 4'd1, 4'd2, 32'h0, "R10 back-to-back");
        idle(4);

        check("R10 queue drained", sb_q.size(), 32'h0);
        check("R7 low bits", {4'h0, flag_word[27:0]}, 32'h0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule